// File: doc/BRIEF.md
# Letterbox Vertical Scan Controller

This block produces the vertical scan timing of an LCD panel driver from incoming line and field sync strobes. It scans in one of two ways. In the plain 4:3 pattern, each incoming line advances the panel by one row. In the letterbox pattern, the picture is squeezed vertically by skipping input lines in a fixed, evenly spread pattern. The empty rows above and below the picture are then swept quickly while black is written into them.

The scan pattern, the line standard (NTSC or PAL) and the panel height variant (short or tall) are all sampled on the field sync strobe. A field therefore always runs one pattern from start to end. A no-signal flag forces the plain pattern whenever it is high at field start. The outputs go to the panel: a field-start pulse, a row-shift pulse, per-row gate and wipe strobes, a black-insert timing level, a panel blanking level, a polarity level and a horizontal-start pulse. During the black sweeps, the polarity and horizontal-start outputs change at the fast sweep rate.

Top module: `vlc_letterbox_vscan`

## Requirements
- R1: The effective mode is latched only in a cycle where `vsync_i` is high: letterbox when `wide_i` is 1 and `nosig_i` is 0, plain otherwise. `pal_i` and `tall_i` are latched in the same cycle. Changes to any of them during a field have no effect until the next field.
- R2: `frame_start_o` is high for exactly the one cycle after each cycle with `vsync_i` high. A `vsync_i` in the middle of a field abandons that field and starts a new one.
- R3: In plain mode, each `hsync_i` after field start gives one cycle of `vshift_o`, `row_gate_o` and `row_wipe_o` (one cycle later). This repeats for 218 lines, or 225 when `tall_i` was latched as 1. Later lines give no shift.
- R4: In letterbox mode, a top black sweep of 28 `vshift_o` pulses starts at field start. A pulse comes every FAST_DIV (default 4) clocks, and the first pulse comes FAST_DIV cycles after `frame_start_o`. `hsync_i` is ignored during the sweep.
- R5: After the top sweep, the letterbox picture holds 163 kept lines, or 169 on the tall variant. Each kept line gives `vshift_o` and `row_gate_o`.
- R6: In the picture region, every `hsync_i` pulses `row_wipe_o`. Index these lines p = 0, 1, … from the start of the picture region in each field. With drop ratio D of N, line p is dropped (no `vshift_o`, no `row_gate_o`) when floor(((p mod N)+1)·D/N) > floor((p mod N)·D/N). The ratio is 1 of 4 for NTSC, 2 of 6 for PAL short, and 10 of 28 for PAL tall. Plain mode drops nothing.
- R7: After the last kept line, a bottom black sweep gives 27 fast `vshift_o` pulses (28 on the tall variant) at the R4 rate. The block then idles until the next field.
- R8: `black_ins_o` and `panel_blank_o` are high one cycle behind the sweep state, so they cover every sweep pulse. `row_gate_o` and `row_wipe_o` are never high together with them.
- R9: `polarity_o` toggles at every field start and at every sweep pulse. `hline_pulse_o` pulses for every `hsync_i` outside the sweeps and for every sweep pulse.
- R10: With `wide_i`=1 and `nosig_i`=1 at field start, the field runs exactly as a plain field.
- R11: While `rst_ni` is low, all outputs are 0 and the block idles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | One-cycle line start strobe |
| vsync_i | input | 1 | One-cycle field start strobe |
| wide_i | input | 1 | Letterbox request |
| pal_i | input | 1 | 1 = PAL line standard, 0 = NTSC |
| tall_i | input | 1 | 1 = tall panel variant |
| nosig_i | input | 1 | No input signal detected |
| frame_start_o | output | 1 | Vertical start pulse |
| vshift_o | output | 1 | Vertical row shift pulse |
| row_gate_o | output | 1 | Row enable strobe for kept lines |
| row_wipe_o | output | 1 | Row clear strobe per picture line |
| black_ins_o | output | 1 | Black insertion timing level |
| panel_blank_o | output | 1 | Panel blanking level |
| polarity_o | output | 1 | Drive polarity level |
| hline_pulse_o | output | 1 | Horizontal start pulse |

## Verification
The bench focuses on the drop pattern at the end of the picture region. For each ratio and variant it checks how many picture lines pass before the last kept line (217, 244, 262 and 225). A misplaced drop phase, or a phase that is not cleared at field start, shifts these counts. The bench also counts the pulses of the top and bottom sweeps on each variant, where an off-by-one in a band limit shows up as 27/29 pulses. Changing the mode in mid-field, raising the no-signal flag and restarting a field early each target a design that samples the mode at the wrong time and so mixes the two patterns within one field. Every output is also compared against a behavioural model on every clock, which catches sweep pulses that are off by one cycle.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TOP  = 2'd1,
    ST_DISP = 2'd2,
    ST_BOT  = 2'd3
  } vlc_state_e;

  typedef struct packed {
    logic wide;
    logic pal;
    logic tall;
  } vlc_mode_t;

  function automatic int vlc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/vlc_field_cfg.sv
module vlc_field_cfg
  import vlc_pkg::*;
#(
  parameter int CNT_W          = 8,
  parameter int DEN_W          = 5,
  parameter int VIS_STD_SHORT  = 218,
  parameter int VIS_STD_TALL   = 225,
  parameter int VIS_WIDE_SHORT = 163,
  parameter int VIS_WIDE_TALL  = 169,
  parameter int BOT_SHORT      = 27,
  parameter int BOT_TALL       = 28,
  parameter int NTSC_DROP      = 1,
  parameter int NTSC_CYC       = 4,
  parameter int PALS_DROP      = 2,
  parameter int PALS_CYC       = 6,
  parameter int PALT_DROP      = 10,
  parameter int PALT_CYC       = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             wide_req,
  input  logic             pal_req,
  input  logic             tall_req,
  output vlc_mode_t        mode_o,
  output logic [CNT_W-1:0] vis_lim_o,
  output logic [CNT_W-1:0] bot_lim_o,
  output logic [DEN_W-1:0] drop_num_o,
  output logic [DEN_W-1:0] drop_den_o
);
  vlc_mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (load) begin
      mode_d.wide = wide_req;
      mode_d.pal  = pal_req;
      mode_d.tall = tall_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  // limits follow the latched field mode only
  always_comb begin
    if (mode_q.wide)
      vis_lim_o = mode_q.tall ? CNT_W'(VIS_WIDE_TALL) : CNT_W'(VIS_WIDE_SHORT);
    else
      vis_lim_o = mode_q.tall ? CNT_W'(VIS_STD_TALL) : CNT_W'(VIS_STD_SHORT);
    bot_lim_o = mode_q.tall ? CNT_W'(BOT_TALL) : CNT_W'(BOT_SHORT);
    if (!mode_q.pal) begin
      drop_num_o = DEN_W'(NTSC_DROP);
      drop_den_o = DEN_W'(NTSC_CYC);
    end else if (mode_q.tall) begin
      drop_num_o = DEN_W'(PALT_DROP);
      drop_den_o = DEN_W'(PALT_CYC);
    end else begin
      drop_num_o = DEN_W'(PALS_DROP);
      drop_den_o = DEN_W'(PALS_CYC);
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/vlc_drop_gen.sv
module vlc_drop_gen #(
  parameter int DEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic             enable,
  input  logic [DEN_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             drop_o
);
  localparam int SUM_W = DEN_W + 1;

  logic [DEN_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0] sum;

  // error accumulator: a line is dropped when the running sum crosses the cycle length
  assign sum    = {1'b0, acc_q} + {1'b0, num};
  assign drop_o = enable && (sum >= {1'b0, den});

  always_comb begin
    acc_d = acc_q;
    if (restart)
      acc_d = '0;
    else if (step && enable)
      acc_d = drop_o ? DEN_W'(sum - {1'b0, den}) : DEN_W'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/vlc_fast_tick.sv
module vlc_fast_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick_o
);
  localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [TW-1:0] t_q, t_d;

  assign tick_o = run && (t_q == TW'(DIV - 1));

  always_comb begin
    t_d = t_q;
    if (restart || !run) t_d = '0;
    else if (tick_o)     t_d = '0;
    else                 t_d = t_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t_q <= '0;
    else        t_q <= t_d;
  end
endmodule

// File: rtl/vlc_letterbox_vscan.sv
module vlc_letterbox_vscan
  import vlc_pkg::*;
#(
  parameter int FAST_DIV       = 4,
  parameter int TOP_LINES      = 28,
  parameter int BOT_SHORT      = 27,
  parameter int BOT_TALL       = 28,
  parameter int VIS_STD_SHORT  = 218,
  parameter int VIS_STD_TALL   = 225,
  parameter int VIS_WIDE_SHORT = 163,
  parameter int VIS_WIDE_TALL  = 169,
  parameter int NTSC_DROP      = 1,
  parameter int NTSC_CYC       = 4,
  parameter int PALS_DROP      = 2,
  parameter int PALS_CYC       = 6,
  parameter int PALT_DROP      = 10,
  parameter int PALT_CYC       = 28
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  input  logic vsync_i,
  input  logic wide_i,
  input  logic pal_i,
  input  logic tall_i,
  input  logic nosig_i,
  output logic frame_start_o,
  output logic vshift_o,
  output logic row_gate_o,
  output logic row_wipe_o,
  output logic black_ins_o,
  output logic panel_blank_o,
  output logic polarity_o,
  output logic hline_pulse_o
);
  localparam int LIM_MAX = vlc_max(vlc_max(vlc_max(VIS_STD_SHORT, VIS_STD_TALL),
                                           vlc_max(VIS_WIDE_SHORT, VIS_WIDE_TALL)),
                                   vlc_max(TOP_LINES, vlc_max(BOT_SHORT, BOT_TALL)));
  localparam int CNT_W   = $clog2(LIM_MAX + 1);
  localparam int CYC_MAX = vlc_max(NTSC_CYC, vlc_max(PALS_CYC, PALT_CYC));
  localparam int DEN_W   = $clog2(CYC_MAX + 1);

  vlc_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] vis_lim, bot_lim, band_lim;
  logic [DEN_W-1:0] drop_num, drop_den;
  vlc_mode_t        field_mode;
  logic             wide_req, in_band, in_disp, tick, drop, disp_step;
  logic             vst_q, vck_q, gate_q, wipe_q, blk_q, pol_q, hln_q;
  logic             vst_d, vck_d, gate_d, wipe_d, blk_d, pol_d, hln_d;

  assign wide_req  = wide_i & ~nosig_i;
  assign in_band   = (st_q == ST_TOP) || (st_q == ST_BOT);
  assign in_disp   = (st_q == ST_DISP);
  assign disp_step = in_disp && hsync_i && !vsync_i;
  assign band_lim  = (st_q == ST_TOP) ? CNT_W'(TOP_LINES) : bot_lim;

  vlc_field_cfg #(
    .CNT_W(CNT_W), .DEN_W(DEN_W),
    .VIS_STD_SHORT(VIS_STD_SHORT), .VIS_STD_TALL(VIS_STD_TALL),
    .VIS_WIDE_SHORT(VIS_WIDE_SHORT), .VIS_WIDE_TALL(VIS_WIDE_TALL),
    .BOT_SHORT(BOT_SHORT), .BOT_TALL(BOT_TALL),
    .NTSC_DROP(NTSC_DROP), .NTSC_CYC(NTSC_CYC),
    .PALS_DROP(PALS_DROP), .PALS_CYC(PALS_CYC),
    .PALT_DROP(PALT_DROP), .PALT_CYC(PALT_CYC)
  ) u_cfg (
    .clk(clk_i), .rst_n(rst_ni), .load(vsync_i),
    .wide_req(wide_req), .pal_req(pal_i), .tall_req(tall_i),
    .mode_o(field_mode), .vis_lim_o(vis_lim), .bot_lim_o(bot_lim),
    .drop_num_o(drop_num), .drop_den_o(drop_den)
  );

  vlc_drop_gen #(.DEN_W(DEN_W)) u_drop (
    .clk(clk_i), .rst_n(rst_ni), .restart(vsync_i), .step(disp_step),
    .enable(field_mode.wide), .num(drop_num), .den(drop_den), .drop_o(drop)
  );

  vlc_fast_tick #(.DIV(FAST_DIV)) u_tick (
    .clk(clk_i), .rst_n(rst_ni), .run(in_band), .restart(vsync_i), .tick_o(tick)
  );

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    vst_d  = 1'b0;
    vck_d  = 1'b0;
    gate_d = 1'b0;
    wipe_d = 1'b0;
    hln_d  = 1'b0;
    pol_d  = pol_q;
    blk_d  = in_band;
    if (vsync_i) begin
      st_d  = wide_req ? ST_TOP : ST_DISP;
      cnt_d = '0;
      vst_d = 1'b1;
      pol_d = ~pol_q;
    end else begin
      unique case (st_q)
        ST_TOP, ST_BOT: begin
          if (tick) begin
            vck_d = 1'b1;
            hln_d = 1'b1;
            pol_d = ~pol_q;
            if (cnt_q == band_lim - CNT_W'(1)) begin
              st_d  = (st_q == ST_TOP) ? ST_DISP : ST_IDLE;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_DISP: begin
          if (hsync_i) begin
            hln_d  = 1'b1;
            wipe_d = 1'b1;
            if (!drop) begin
              vck_d  = 1'b1;
              gate_d = 1'b1;
              if (cnt_q == vis_lim - CNT_W'(1)) begin
                st_d  = field_mode.wide ? ST_BOT : ST_IDLE;
                cnt_d = '0;
              end else begin
                cnt_d = cnt_q + CNT_W'(1);
              end
            end
          end
        end
        default: begin
          if (hsync_i) hln_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      vst_q  <= 1'b0;
      vck_q  <= 1'b0;
      gate_q <= 1'b0;
      wipe_q <= 1'b0;
      blk_q  <= 1'b0;
      pol_q  <= 1'b0;
      hln_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      vst_q  <= vst_d;
      vck_q  <= vck_d;
      gate_q <= gate_d;
      wipe_q <= wipe_d;
      blk_q  <= blk_d;
      pol_q  <= pol_d;
      hln_q  <= hln_d;
    end
  end

  assign frame_start_o = vst_q;
  assign vshift_o      = vck_q;
  assign row_gate_o    = gate_q;
  assign row_wipe_o    = wipe_q;
  assign black_ins_o   = blk_q;
  assign panel_blank_o = blk_q;
  assign polarity_o    = pol_q;
  assign hline_pulse_o = hln_q;
endmodule

// File: rtl/vlc_letterbox_checker.sv
module vlc_letterbox_checker
  import vlc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      vsync,
  input logic      nosig,
  input logic      vst,
  input logic      vck,
  input logic      gate,
  input logic      wipe,
  input logic      sblk,
  input vlc_mode_t mode
);
  // R2: a field start pulse only follows a field sync
  p_start_after_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vst |-> $past(vsync));

  // R2: every field sync yields a field start pulse
  p_sync_gives_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> vst);

  // R8: no row strobes while black is being swept
  p_band_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sblk |-> (!gate && !wipe));

  // R4: fast sweep pulses are never back to back
  p_band_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sblk && vck) |=> !vck);

  // R6: a kept row is also shifted and wiped
  p_kept_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (vck && wipe));

  // R1: the latched mode only changes on a field sync
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(mode));

  // R10: no-signal at field start forces the plain pattern
  p_nosig_plain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && nosig) |=> !mode.wide);

  // R3: a plain field that follows a plain field shows no black sweep
  p_plain_no_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.wide && $past(!mode.wide)) |-> !sblk);
endmodule

bind vlc_letterbox_vscan vlc_letterbox_checker u_chk (
  .clk(clk_i), .rst_n(rst_ni), .vsync(vsync_i), .nosig(nosig_i),
  .vst(frame_start_o), .vck(vshift_o), .gate(row_gate_o), .wipe(row_wipe_o),
  .sblk(black_ins_o), .mode(field_mode)
);

// File: tb/tb_vlc_letterbox_vscan.sv
module tb_vlc_letterbox_vscan;
  localparam int FD = 4;
  localparam int HP = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, hs, vs, wide, pal, tall, nosig;
  logic vst, vck, gate, wipe, sblk, blank, pol, hln;

  vlc_letterbox_vscan dut (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .vsync_i(vs),
    .wide_i(wide), .pal_i(pal), .tall_i(tall), .nosig_i(nosig),
    .frame_start_o(vst), .vshift_o(vck), .row_gate_o(gate), .row_wipe_o(wipe),
    .black_ins_o(sblk), .panel_blank_o(blank), .polarity_o(pol), .hline_pulse_o(hln)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: state 0 idle, 1 top sweep, 2 picture, 3 bottom sweep
  int m_st, m_cnt, m_t, m_p;
  bit m_wide, m_pal, m_tall;
  bit e_vst, e_vck, e_gate, e_wipe, e_blk, e_pol, e_hln;

  function automatic int vis_of(bit w, bit t);
    if (w) return t ? 169 : 163;
    return t ? 225 : 218;
  endfunction
  function automatic int dn_num(bit p, bit t);
    if (!p) return 1;
    return t ? 10 : 2;
  endfunction
  function automatic int dn_cyc(bit p, bit t);
    if (!p) return 4;
    return t ? 28 : 6;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_t = 0; m_p = 0;
      m_wide = 0; m_pal = 0; m_tall = 0;
      e_vst = 0; e_vck = 0; e_gate = 0; e_wipe = 0; e_blk = 0; e_pol = 0; e_hln = 0;
    end else begin
      e_blk = (m_st == 1) || (m_st == 3);
      e_vst = 0; e_vck = 0; e_gate = 0; e_wipe = 0; e_hln = 0;
      if (vs) begin
        m_wide = wide && !nosig; m_pal = pal; m_tall = tall;
        m_st = m_wide ? 1 : 2; m_cnt = 0; m_t = 0; m_p = 0;
        e_vst = 1; e_pol = !e_pol;
      end else if (m_st == 1 || m_st == 3) begin
        if (m_t == FD - 1) begin
          m_t = 0; e_vck = 1; e_hln = 1; e_pol = !e_pol;
          if (m_cnt == ((m_st == 1) ? 28 : (m_tall ? 28 : 27)) - 1) begin
            m_st = (m_st == 1) ? 2 : 0; m_cnt = 0;
          end else m_cnt++;
        end else m_t++;
      end else if (m_st == 2) begin
        if (hs) begin
          int n, d;
          bit dropped;
          n = dn_cyc(m_pal, m_tall); d = dn_num(m_pal, m_tall);
          dropped = m_wide && (((m_p + 1) * d) / n > (m_p * d) / n);
          m_p = (m_p + 1) % n;
          e_hln = 1; e_wipe = 1;
          if (!dropped) begin
            e_vck = 1; e_gate = 1;
            if (m_cnt == vis_of(m_wide, m_tall) - 1) begin
              m_st = m_wide ? 3 : 0; m_cnt = 0; m_t = 0;
            end else m_cnt++;
          end
        end
      end else begin
        if (hs) e_hln = 1;
      end
    end
  end

  // per-field tallies taken at the ports
  int top_n, disp_n, bot_n, wipe_n;
  bit seen_gate;

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 frame_start", vst, e_vst);
      chk("R5 vshift", vck, e_vck);
      chk("R6 row_gate", gate, e_gate);
      chk("R3 row_wipe", wipe, e_wipe);
      chk("R8 black_ins", sblk, e_blk);
      chk("R8 panel_blank", blank, e_blk);
      chk("R9 polarity", pol, e_pol);
      chk("R9 hline_pulse", hln, e_hln);
      if (vs) begin
        top_n = 0; disp_n = 0; bot_n = 0; wipe_n = 0; seen_gate = 0;
      end else begin
        if (gate) begin disp_n++; seen_gate = 1; end
        if (wipe) wipe_n++;
        if (vck && !gate) begin
          if (seen_gate) bot_n++;
          else top_n++;
        end
      end
    end
  end

  task automatic run_field(input bit w, input bit p, input bit t, input bit ns,
                           input int nl, input int flip_at);
    @(posedge clk); #1;
    wide = w; pal = p; tall = t; nosig = ns; vs = 1'b1;
    @(posedge clk); #1;
    vs = 1'b0;
    for (int l = 0; l < nl; l++) begin
      if (l == flip_at) begin wide = !wide; nosig = 1'b0; end
      repeat (HP - 1) @(posedge clk);
      #1 hs = 1'b1;
      @(posedge clk); #1 hs = 1'b0;
    end
    repeat (40) @(posedge clk);
    #1;
  endtask

  task automatic check_field(input string tag, input int et, input int ed,
                             input int eb, input int ew);
    chk({tag, " R4 top sweep pulses"}, top_n, et);
    chk({tag, " R5 kept lines"}, disp_n, ed);
    chk({tag, " R7 bottom sweep pulses"}, bot_n, eb);
    chk({tag, " R6 picture lines used"}, wipe_n, ew);
  endtask

  initial begin
    rst_n = 1'b0; hs = 0; vs = 0; wide = 0; pal = 0; tall = 0; nosig = 0;
    top_n = 0; disp_n = 0; bot_n = 0; wipe_n = 0; seen_gate = 0;
    fork
      begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11: outputs idle during reset
        chk("R11 reset outputs", {vst, vck, gate, wipe, sblk, blank, pol, hln}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (3) @(posedge clk); #1;
        // R3: plain NTSC short and plain PAL tall
        run_field(0, 0, 0, 0, 300, -1); check_field("plain short", 0, 218, 0, 218);
        run_field(0, 1, 1, 0, 300, -1); check_field("plain tall", 0, 225, 0, 225);
        // R6: each drop ratio and variant
        run_field(1, 0, 0, 0, 300, -1); check_field("wide ntsc short", 28, 163, 27, 217);
        run_field(1, 1, 0, 0, 300, -1); check_field("wide pal short", 28, 163, 27, 244);
        run_field(1, 1, 1, 0, 300, -1); check_field("wide pal tall", 28, 169, 28, 262);
        run_field(1, 0, 1, 0, 300, -1); check_field("wide ntsc tall", 28, 169, 28, 225);
        // R10: no-signal fallback
        run_field(1, 0, 0, 1, 300, -1); check_field("R10 nosig", 0, 218, 0, 218);
        // R1: mid-field wide request is ignored
        run_field(0, 0, 0, 0, 300, 100); check_field("R1 flip", 0, 218, 0, 218);
        // R1: mid-field no-signal drop does not turn a plain field wide
        run_field(1, 0, 0, 1, 300, 60); check_field("R1 nosig flip", 0, 218, 0, 218);
        // R2: an early field sync restarts the pattern cleanly
        run_field(1, 0, 0, 0, 50, -1);
        run_field(1, 1, 0, 0, 300, -1); check_field("R2 restart", 28, 163, 27, 244);
      end
      begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule